// File: doc/BRIEF.md
# Atomic 32-bit Timer Behind a 16-bit Register Port

The block holds a 32-bit up-counter that runs freely and four 32-bit capture registers. Each capture register takes a snapshot of the counter when its trigger input is high. Software reaches these values over a register port that carries only 16 bits. A 32-bit value therefore moves in two accesses: the upper half goes first and the lower half second.

One hidden holding register makes each split access atomic. A read of an upper half returns that half. On the same clock edge, the holding register takes the lower half of the same value, and the following lower-half read returns that parked copy. A write of the counter's upper half only fills the holding register. The lower-half write then commits the parked upper half and the new lower half in one edge. Because of this, a 32-bit value never tears across a carry out of the low half, even while the counter keeps running.

Top module: `wide_timer_bridge`

## Requirements
- R1: While `rst_n` is low, the counter, all capture registers, the holding register and `bus_rdata` are zero.
- R2: On each rising edge with `count_en` high and no counter load, the counter goes up by one and wraps from 0xFFFFFFFF to 0. With `count_en` low and no load, the counter holds its value.
- R3: `bus_addr` bit 0 selects the half: 0 is the upper half and 1 is the lower half. `bus_addr[3:1]` selects the register: 0 is the counter and 1 to 4 are capture registers 0 to 3. `bus_rdata` is registered. It changes on the rising edge that samples `bus_rd` and holds its value in every other cycle.
- R4: A read of an upper half returns bits 31:16 of the register's value at that edge. On the same edge, bits 15:0 of that value are stored in the holding register.
- R5: A read of any mapped lower-half address returns the holding register's content, whichever register last filled it. It does not return the live lower half.
- R6: A write to the counter's upper half stores `bus_wdata` in the holding register only. The counter is not changed.
- R7: A write to the counter's lower half loads the counter with {holding register, `bus_wdata`} on a single edge.
- R8: When a counter load and an enabled count fall on the same edge, the load wins. The counter takes the written value and does not add one on that edge.
- R9: With `cap_trig[k]` high at an edge, capture register k takes the counter value present before that edge's update. Without a trigger, the capture register holds its value.
- R10: Writes to capture-register addresses have no effect. Neither the capture registers nor the holding register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register/half select, see R3 |
| bus_rd | input | 1 | Read strobe, one access per cycle held high |
| bus_wr | input | 1 | Write strobe, takes precedence over `bus_rd` |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| count_en | input | 1 | Counter increment enable |
| cap_trig | input | 4 | One trigger per capture register |

## Verification
Every result of this block is due on the first rising edge after a strobe or trigger is sampled. That edge updates `bus_rdata`, the holding register, the counter load and the capture snapshot. So a read issued in the cycle after a write already sees the written value. The bench drives each operation on the falling edge and reads `bus_rdata` one time unit after the following rising edge, which is exactly the cycle in which the value for that read is due. Where the counter runs, the expected values count the enabled edges between the load and the read. The cases covered are a read taken while the low half carries, a capture taken on an incrementing edge, a load that coincides with an increment, and the wrap from all-ones to zero.

// File: rtl/wtb_pkg.sv
package wtb_pkg;
    typedef enum logic {
        HALF_UPPER = 1'b0,
        HALF_LOWER = 1'b1
    } half_sel_e;
endpackage

// File: rtl/wtb_counter.sv
module wtb_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.value = load_val;
        end else if (count_en) begin
            st_d.value = st_q.value + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.value;

    // R2: increment, wrap and hold
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !load_en) |=> (cnt == $past(cnt) + CNT_W'(1)));
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !load_en) |=> $stable(cnt));
    // R8: load beats increment
    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (cnt == $past(load_val)));
endmodule

// File: rtl/wtb_capture.sv
module wtb_capture #(
    parameter int CNT_W = 32,
    parameter int N_CAP = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CAP-1:0]            trig,
    input  logic [CNT_W-1:0]            cnt,
    output logic [N_CAP-1:0][CNT_W-1:0] caps
);
    typedef struct packed {
        logic [N_CAP-1:0][CNT_W-1:0] snap;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < N_CAP; k++) begin
            if (trig[k]) st_d.snap[k] = cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign caps = st_q.snap;

    for (genvar g = 0; g < N_CAP; g++) begin : g_chk
        // R9: snapshot of pre-update counter, hold otherwise
        assert_capture_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
            trig[g] |=> (caps[g] == $past(cnt)));
        assert_capture_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !trig[g] |=> $stable(caps[g]));
    end
endmodule

// File: rtl/wtb_regport.sv
module wtb_regport #(
    parameter int CNT_W  = 32,
    parameter int N_CAP  = 4,
    parameter int ADDR_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_rd,
    input  logic                        bus_wr,
    input  logic [CNT_W/2-1:0]          bus_wdata,
    input  logic [CNT_W-1:0]            cnt,
    input  logic [N_CAP-1:0][CNT_W-1:0] caps,
    output logic [CNT_W/2-1:0]          bus_rdata,
    output logic                        load_en,
    output logic [CNT_W-1:0]            load_val
);
    import wtb_pkg::*;

    localparam int HALF_W = CNT_W / 2;
    localparam int IDX_W  = ADDR_W - 1;
    localparam int N_REG  = N_CAP + 1;

    typedef struct packed {
        logic [HALF_W-1:0] hold;
        logic [HALF_W-1:0] rdata;
    } port_state_t;

    port_state_t st_d, st_q;

    logic [N_REG-1:0][CNT_W-1:0] regs;
    logic [IDX_W-1:0]            idx;
    half_sel_e                   half;
    logic                        mapped;
    logic [CNT_W-1:0]            sel_val;
    logic                        cnt_hi_wr;
    logic                        cnt_lo_wr;

    assign regs[0] = cnt;
    for (genvar g = 0; g < N_CAP; g++) begin : g_regs
        assign regs[g+1] = caps[g];
    end

    always_comb begin
        idx     = bus_addr[ADDR_W-1:1];
        half    = half_sel_e'(bus_addr[0]);
        mapped  = 1'b0;
        sel_val = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (idx == IDX_W'(i)) begin
                mapped  = 1'b1;
                sel_val = regs[i];
            end
        end
        cnt_hi_wr = bus_wr && (idx == '0) && (half == HALF_UPPER);
        cnt_lo_wr = bus_wr && (idx == '0) && (half == HALF_LOWER);
    end

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            if (cnt_hi_wr) st_d.hold = bus_wdata;
        end else if (bus_rd) begin
            if (!mapped) begin
                st_d.rdata = '0;
            end else if (half == HALF_UPPER) begin
                st_d.rdata = sel_val[CNT_W-1:HALF_W];
                st_d.hold  = sel_val[HALF_W-1:0];
            end else begin
                st_d.rdata = st_q.hold;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign load_en   = cnt_lo_wr;
    assign load_val  = {st_q.hold, bus_wdata};

    // R1: state leaves reset cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (st_q.hold == '0 && bus_rdata == '0));
    // R4: upper read returns upper half and parks lower half
    assert_upper_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && mapped && half == HALF_UPPER) |=>
        (bus_rdata == $past(sel_val[CNT_W-1:HALF_W]) &&
         st_q.hold == $past(sel_val[HALF_W-1:0])));
    // R5: lower read returns parked half
    assert_lower_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && mapped && half == HALF_LOWER) |=>
        (bus_rdata == $past(st_q.hold)));
    // R3: read data holds without a read
    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || bus_wr) |=> $stable(bus_rdata));
    // R6: upper write is parked
    assert_upper_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_hi_wr |=> (st_q.hold == $past(bus_wdata)));
    // R10: capture-address writes leave the holding register alone
    assert_cap_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx != '0) |=> $stable(st_q.hold));
endmodule

// File: rtl/wide_timer_bridge.sv
module wide_timer_bridge #(
    parameter int CNT_W  = 32,
    parameter int N_CAP  = 4,
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [CNT_W/2-1:0]   bus_wdata,
    output logic [CNT_W/2-1:0]   bus_rdata,
    input  logic                 count_en,
    input  logic [N_CAP-1:0]     cap_trig
);
    localparam int HALF_W = CNT_W / 2;

    logic [CNT_W-1:0]            cnt;
    logic [N_CAP-1:0][CNT_W-1:0] caps;
    logic                        load_en;
    logic [CNT_W-1:0]            load_val;

    wtb_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .load_en  (load_en),
        .load_val (load_val),
        .cnt      (cnt)
    );

    wtb_capture #(.CNT_W(CNT_W), .N_CAP(N_CAP)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (cap_trig),
        .cnt   (cnt),
        .caps  (caps)
    );

    wtb_regport #(.CNT_W(CNT_W), .N_CAP(N_CAP), .ADDR_W(ADDR_W)) u_regport (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .cnt       (cnt),
        .caps      (caps),
        .bus_rdata (bus_rdata),
        .load_en   (load_en),
        .load_val  (load_val)
    );

    // R7: lower write commits the full word on one edge
    assert_lower_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(1)) |=>
        (cnt[HALF_W-1:0] == $past(bus_wdata) &&
         cnt[CNT_W-1:HALF_W] == $past(load_val[CNT_W-1:HALF_W])));
    // R6: upper write leaves a stopped counter untouched
    assert_upper_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0) && !count_en) |=> $stable(cnt));
endmodule

// File: tb/wide_timer_bridge_tb_top.sv
module wide_timer_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    localparam logic [1:0] OP_IDLE = 2'd0;
    localparam logic [1:0] OP_WR   = 2'd1;
    localparam logic [1:0] OP_RD   = 2'd2;

    typedef struct packed {
        logic [1:0]  kind;
        logic [3:0]  addr;
        logic [15:0] data;
        logic        en;
        logic [3:0]  trig;
        logic [15:0] exp;
        logic [3:0]  req;
    } op_t;

    localparam int N_OPS = 47;
    localparam op_t OPS [N_OPS] = '{
        '{OP_RD,   4'd0, 16'h0000, 1'b0, 4'b0000, 16'h0000, 4'd1},  // R1 counter upper
        '{OP_RD,   4'd1, 16'h0000, 1'b0, 4'b0000, 16'h0000, 4'd1},  // R1 counter lower
        '{OP_RD,   4'd2, 16'h0000, 1'b0, 4'b0000, 16'h0000, 4'd1},  // R1 capture 0 upper
        '{OP_WR,   4'd0, 16'h1234, 1'b0, 4'b0000, 16'h0000, 4'd6},  // R6 park upper
        '{OP_RD,   4'd1, 16'h0000, 1'b0, 4'b0000, 16'h1234, 4'd5},  // R5 lower read sees parked word
        '{OP_RD,   4'd0, 16'h0000, 1'b0, 4'b0000, 16'h0000, 4'd6},  // R6 counter untouched
        '{OP_WR,   4'd0, 16'hABCD, 1'b0, 4'b0000, 16'h0000, 4'd7},
        '{OP_WR,   4'd1, 16'h5678, 1'b0, 4'b0000, 16'h0000, 4'd7},  // R7 commit
        '{OP_RD,   4'd0, 16'h0000, 1'b0, 4'b0000, 16'hABCD, 4'd7},
        '{OP_RD,   4'd1, 16'h0000, 1'b0, 4'b0000, 16'h5678, 4'd7},
        '{OP_IDLE, 4'd0, 16'h0000, 1'b1, 4'b0000, 16'h0000, 4'd2},
        '{OP_IDLE, 4'd0, 16'h0000, 1'b1, 4'b0000, 16'h0000, 4'd2},
        '{OP_RD,   4'd0, 16'h0000, 1'b0, 4'b0000, 16'hABCD, 4'd2},  // R2 two increments
        '{OP_RD,   4'd1, 16'h0000, 1'b0, 4'b0000, 16'h567A, 4'd2},
        '{OP_WR,   4'd0, 16'h0000, 1'b0, 4'b0000, 16'h0000, 4'd4},
        '{OP_WR,   4'd1, 16'hFFFF, 1'b1, 4'b0000, 16'h0000, 4'd4},  // load 0000FFFF while counting
        '{OP_RD,   4'd0, 16'h0000, 1'b1, 4'b0000, 16'h0000, 4'd4},  // R4 upper read on carry edge
        '{OP_RD,   4'd1, 16'h0000, 1'b0, 4'b0000, 16'hFFFF, 4'd4},  // R4 coherent lower half
        '{OP_RD,   4'd0, 16'h0000, 1'b0, 4'b0000, 16'h0001, 4'd2},  // R2 carry happened
        '{OP_RD,   4'd1, 16'h0000, 1'b0, 4'b0000, 16'h0000, 4'd2},
        '{OP_WR,   4'd0, 16'h1111, 1'b0, 4'b0000, 16'h0000, 4'd8},
        '{OP_WR,   4'd1, 16'h2222, 1'b1, 4'b0000, 16'h0000, 4'd8},  // R8 load with count_en high
        '{OP_RD,   4'd0, 16'h0000, 1'b0, 4'b0000, 16'h1111, 4'd8},
        '{OP_RD,   4'd1, 16'h0000, 1'b0, 4'b0000, 16'h2222, 4'd8},
        '{OP_IDLE, 4'd0, 16'h0000, 1'b0, 4'b0100, 16'h0000, 4'd9},  // R9 capture 2 while stopped
        '{OP_RD,   4'd6, 16'h0000, 1'b0, 4'b0000, 16'h1111, 4'd9},
        '{OP_RD,   4'd7, 16'h0000, 1'b0, 4'b0000, 16'h2222, 4'd9},
        '{OP_IDLE, 4'd0, 16'h0000, 1'b1, 4'b0001, 16'h0000, 4'd9},  // R9 capture 0 on counting edge
        '{OP_RD,   4'd2, 16'h0000, 1'b0, 4'b0000, 16'h1111, 4'd9},
        '{OP_RD,   4'd3, 16'h0000, 1'b0, 4'b0000, 16'h2222, 4'd9},  // pre-increment value
        '{OP_WR,   4'd2, 16'hDEAD, 1'b0, 4'b0000, 16'h0000, 4'd10},
        '{OP_WR,   4'd3, 16'hBEEF, 1'b0, 4'b0000, 16'h0000, 4'd10},
        '{OP_RD,   4'd2, 16'h0000, 1'b0, 4'b0000, 16'h1111, 4'd10}, // R10 capture unchanged
        '{OP_RD,   4'd3, 16'h0000, 1'b0, 4'b0000, 16'h2222, 4'd10},
        '{OP_WR,   4'd0, 16'h4444, 1'b0, 4'b0000, 16'h0000, 4'd10},
        '{OP_WR,   4'd4, 16'h9999, 1'b0, 4'b0000, 16'h0000, 4'd10}, // capture 1 upper write ignored
        '{OP_WR,   4'd1, 16'h0001, 1'b0, 4'b0000, 16'h0000, 4'd10},
        '{OP_RD,   4'd0, 16'h0000, 1'b0, 4'b0000, 16'h4444, 4'd10}, // R10 holding reg kept 4444
        '{OP_RD,   4'd1, 16'h0000, 1'b0, 4'b0000, 16'h0001, 4'd10},
        '{OP_RD,   4'd0, 16'h0000, 1'b0, 4'b0000, 16'h4444, 4'd5},
        '{OP_RD,   4'd6, 16'h0000, 1'b0, 4'b0000, 16'h1111, 4'd5},  // refill holding reg from capture 2
        '{OP_RD,   4'd1, 16'h0000, 1'b0, 4'b0000, 16'h2222, 4'd5},  // R5 shared holding reg
        '{OP_WR,   4'd0, 16'hFFFF, 1'b0, 4'b0000, 16'h0000, 4'd2},
        '{OP_WR,   4'd1, 16'hFFFF, 1'b0, 4'b0000, 16'h0000, 4'd2},
        '{OP_IDLE, 4'd0, 16'h0000, 1'b1, 4'b0000, 16'h0000, 4'd2},  // wrap edge
        '{OP_RD,   4'd0, 16'h0000, 1'b0, 4'b0000, 16'h0000, 4'd2},  // R2 wrapped to zero
        '{OP_RD,   4'd1, 16'h0000, 1'b0, 4'b0000, 16'h0000, 4'd2}
    };

    logic        clk;
    logic        rst_n;
    logic [3:0]  bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        count_en;
    logic [3:0]  cap_trig;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    wide_timer_bridge dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count_en  (count_en),
        .cap_trig  (cap_trig)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp,
                         input int step);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d step %0d actual %h expected %h", req, step, act, exp);
        end
    endtask

    task automatic run_op(input op_t op, input int step);
        @(negedge clk);
        bus_rd    = (op.kind == OP_RD);
        bus_wr    = (op.kind == OP_WR);
        bus_addr  = op.addr;
        bus_wdata = op.data;
        count_en  = op.en;
        cap_trig  = op.trig;
        @(posedge clk);
        #1;
        if (op.kind == OP_RD) check(int'(op.req), bus_rdata, op.exp, step);
    endtask

    task automatic idle_bus();
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        count_en = 1'b0; cap_trig = '0;
    endtask

    initial begin
        rst_n = 1'b0;
        bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        count_en = 1'b0; cap_trig = '0;
        repeat (3) @(posedge clk);
        #1;
        check(1, bus_rdata, 16'h0000, -1);  // R1 output cleared in reset
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < N_OPS; i++) run_op(OPS[i], i);
        idle_bus();

        // R1: reset mid-run clears counter, captures and read data
        run_op('{OP_WR, 4'd0, 16'h7777, 1'b0, 4'b0000, 16'h0000, 4'd1}, 100);
        run_op('{OP_WR, 4'd1, 16'h8888, 1'b0, 4'b1000, 16'h0000, 4'd1}, 101);
        run_op('{OP_RD, 4'd0, 16'h0000, 1'b0, 4'b1000, 16'h7777, 4'd1}, 102);
        idle_bus();
        rst_n = 1'b0;
        #1;
        check(1, bus_rdata, 16'h0000, 103);  // R1 asynchronous clear
        @(negedge clk);
        rst_n = 1'b1;
        run_op('{OP_RD, 4'd0, 16'h0000, 1'b0, 4'b0000, 16'h0000, 4'd1}, 104);
        run_op('{OP_RD, 4'd1, 16'h0000, 1'b0, 4'b0000, 16'h0000, 4'd1}, 105);
        run_op('{OP_RD, 4'd8, 16'h0000, 1'b0, 4'b0000, 16'h0000, 4'd1}, 106);
        run_op('{OP_RD, 4'd9, 16'h0000, 1'b0, 4'b0000, 16'h0000, 4'd1}, 107);

        // R3: read data holds while no read is issued
        run_op('{OP_WR, 4'd0, 16'h0F0F, 1'b0, 4'b0000, 16'h0000, 4'd3}, 108);
        run_op('{OP_WR, 4'd1, 16'hF0F0, 1'b0, 4'b0000, 16'h0000, 4'd3}, 109);
        run_op('{OP_RD, 4'd0, 16'h0000, 1'b0, 4'b0000, 16'h0F0F, 4'd3}, 110);
        idle_bus();
        @(posedge clk);
        #1;
        check(3, bus_rdata, 16'h0F0F, 111);  // R3 held across idle cycles
        run_op('{OP_RD, 4'd1, 16'h0000, 1'b0, 4'b0000, 16'hF0F0, 4'd3}, 112);
        idle_bus();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule